// File: doc/BRIEF.md
# Dual-View Scratchpad Address Decoder

This block sits on the request path of a cluster of eight accelerator harts. It turns a 36-bit physical address, tagged with the index of the hart that issued it, into a target region, a chunk index and a byte offset inside that region. The regions are shared executable memory, two aliases of the per-core scratchpad, a small per-hart block of DMA control registers, and DRAM.

The per-core scratchpad can be reached through two aliases. In the private alias, every hart sees only its own chunk, so the chunk index is the requester's index. In the combined alias, all chunks sit one after another in ascending core order, so the chunk index comes from the address. This lets a DMA engine reach any core's scratchpad. An address that falls in no region, or a private-alias offset past the end of one chunk, raises a decode error and selects no target. Decoding is combinational and its result is captured in one output register each time the request strobe is high.

Top module: `dual_view_addr_decoder`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_valid is 0, out_region is 0 (none), out_chunk is 0, out_offset is 0 and out_err is 0.
- R2: A request sampled with in_valid high appears on the outputs one clock later with out_valid high. After a cycle with in_valid low, out_valid is low and out_region, out_chunk, out_offset and out_err keep their previous values.
- R3: An address from 0x0_0000_1000 to 0x0_001F_FFFF gives region 1 (executable), chunk 0 and offset address − 0x1000, for any requester.
- R4: An address 0x0_1000_0000 + d with d below the chunk size (1 MB by default) gives region 2 (private scratchpad), chunk equal to the requester index and offset d.
- R5: An address in 0x0_1000_0000 to 0x0_103F_FFFF whose offset d is at or above the chunk size gives out_err = 1, region 0, chunk 0 and offset 0.
- R6: An address 0x0_1800_0000 + a up to 0x0_187F_FFFF gives region 3 (combined scratchpad), chunk a / chunk size and offset a mod chunk size, for any requester.
- R7: A private access from core k with offset d and a combined access at k × chunk size + d, issued by any hart, give the same chunk k and the same offset d.
- R8: An address from 0x0_2000_2000 to 0x0_2000_20FF gives region 4 (DMA registers), chunk equal to the requester index and offset equal to the address's low 8 bits.
- R9: An address from 0x0_4000_0000 to 0x1_3FFF_FFFF gives region 5 (DRAM), chunk 0 and offset address − 0x4000_0000.
- R10: Any address outside all listed ranges, including the first address past either end of each range, gives out_err = 1, region 0, chunk 0 and offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; the decode is captured when high |
| in_addr | input | 36 | Physical address of the request |
| in_req_id | input | 3 | Index of the requesting hart/core |
| out_valid | output | 1 | A decoded result is present this cycle |
| out_region | output | 3 | 0 none, 1 executable, 2 private scratchpad, 3 combined scratchpad, 4 DMA registers, 5 DRAM |
| out_chunk | output | 3 | Scratchpad chunk index, or requester index for DMA registers |
| out_offset | output | 36 | Byte offset inside the selected chunk or region |
| out_err | output | 1 | Decode error; no target selected |

## Verification
The assertions check on every cycle that a strobe produces a result one cycle later, that idle cycles hold the outputs, that an error never comes with a target, that a private hit always carries the requester's own index, and that scratchpad and DMA offsets stay inside their chunk or register block. Only the bench's scenarios can show the exact offsets and chunk numbers for each range, the first and last addresses of every window along with their outside neighbours, and the agreement between the private and combined aliases for each of the eight cores.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  localparam int REGION_W = 3;

  typedef enum logic [REGION_W-1:0] {
    REG_NONE = 3'd0,
    REG_EXEC = 3'd1,
    REG_PRIV = 3'd2,
    REG_COMB = 3'd3,
    REG_DMA  = 3'd4,
    REG_DRAM = 3'd5
  } region_e;

endpackage

// File: rtl/dsd_window.sv
module dsd_window #(
  parameter int              AW   = 36,
  parameter logic [AW-1:0]   BASE = '0,
  parameter logic [AW-1:0]   LAST = '1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);

  // Inclusive range test; offset relative to the window base.
  always_comb begin
    hit    = (addr >= BASE) && (addr <= LAST);
    offset = addr - BASE;
  end

endmodule

// File: rtl/dsd_scratch_map.sv
module dsd_scratch_map #(
  parameter int AW        = 36,
  parameter int NUM_CORES = 8,
  parameter int IDX_W     = 3,
  parameter int CHUNK_LG  = 20
) (
  input  logic             priv_hit,
  input  logic             comb_hit,
  input  logic [AW-1:0]    priv_off,
  input  logic [AW-1:0]    comb_off,
  input  logic [IDX_W-1:0] req_id,
  output logic             ok,
  output logic [IDX_W-1:0] chunk,
  output logic [AW-1:0]    offset
);

  localparam logic [AW-1:0] CHUNK_BYTES = AW'(1) << CHUNK_LG;
  localparam logic [AW-1:0] CHUNK_MASK  = CHUNK_BYTES - AW'(1);
  localparam logic [AW-1:0] CORE_LIMIT  = AW'(NUM_CORES);

  logic [AW-1:0] comb_idx;

  assign comb_idx = comb_off >> CHUNK_LG;

  // Private alias: chunk comes from the requester. Combined alias: chunk
  // comes from the address, chunks laid out in ascending core order.
  always_comb begin
    ok     = 1'b0;
    chunk  = '0;
    offset = '0;
    if (priv_hit) begin
      if (priv_off < CHUNK_BYTES) begin
        ok     = 1'b1;
        chunk  = req_id;
        offset = priv_off;
      end
    end else if (comb_hit) begin
      if (comb_idx < CORE_LIMIT) begin
        ok     = 1'b1;
        chunk  = comb_idx[IDX_W-1:0];
        offset = comb_off & CHUNK_MASK;
      end
    end
  end

endmodule

// File: rtl/dual_view_addr_decoder.sv
module dual_view_addr_decoder
  import dsd_pkg::*;
#(
  parameter int                  ADDR_W    = 36,
  parameter int                  NUM_CORES = 8,
  parameter int                  CHUNK_LG  = 20,
  parameter logic [ADDR_W-1:0]   EXEC_BASE = 36'h0_0000_1000,
  parameter logic [ADDR_W-1:0]   EXEC_LAST = 36'h0_001F_FFFF,
  parameter logic [ADDR_W-1:0]   PRIV_BASE = 36'h0_1000_0000,
  parameter logic [ADDR_W-1:0]   PRIV_LAST = 36'h0_103F_FFFF,
  parameter logic [ADDR_W-1:0]   COMB_BASE = 36'h0_1800_0000,
  parameter logic [ADDR_W-1:0]   COMB_LAST = 36'h0_187F_FFFF,
  parameter logic [ADDR_W-1:0]   DMA_BASE  = 36'h0_2000_2000,
  parameter logic [ADDR_W-1:0]   DMA_LAST  = 36'h0_2000_20FF,
  parameter logic [ADDR_W-1:0]   DRAM_BASE = 36'h0_4000_0000,
  parameter logic [ADDR_W-1:0]   DRAM_LAST = 36'h1_3FFF_FFFF,
  localparam int                 IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [IDX_W-1:0]    in_req_id,
  output logic                out_valid,
  output logic [REGION_W-1:0] out_region,
  output logic [IDX_W-1:0]    out_chunk,
  output logic [ADDR_W-1:0]   out_offset,
  output logic                out_err
);

  localparam logic [ADDR_W-1:0] CHUNK_BYTES = ADDR_W'(1) << CHUNK_LG;
  localparam logic [ADDR_W-1:0] DMA_SPAN    = DMA_LAST - DMA_BASE + ADDR_W'(1);

  // ---------------- window matchers ----------------
  logic              exec_hit, priv_hit, comb_hit, dma_hit, dram_hit;
  logic [ADDR_W-1:0] exec_off, priv_off, comb_off, dma_off, dram_off;

  dsd_window #(.AW(ADDR_W), .BASE(EXEC_BASE), .LAST(EXEC_LAST)) u_win_exec (
    .addr(in_addr), .hit(exec_hit), .offset(exec_off));
  dsd_window #(.AW(ADDR_W), .BASE(PRIV_BASE), .LAST(PRIV_LAST)) u_win_priv (
    .addr(in_addr), .hit(priv_hit), .offset(priv_off));
  dsd_window #(.AW(ADDR_W), .BASE(COMB_BASE), .LAST(COMB_LAST)) u_win_comb (
    .addr(in_addr), .hit(comb_hit), .offset(comb_off));
  dsd_window #(.AW(ADDR_W), .BASE(DMA_BASE),  .LAST(DMA_LAST))  u_win_dma  (
    .addr(in_addr), .hit(dma_hit),  .offset(dma_off));
  dsd_window #(.AW(ADDR_W), .BASE(DRAM_BASE), .LAST(DRAM_LAST)) u_win_dram (
    .addr(in_addr), .hit(dram_hit), .offset(dram_off));

  // ---------------- scratchpad alias resolution ----------------
  logic              sp_ok;
  logic [IDX_W-1:0]  sp_chunk;
  logic [ADDR_W-1:0] sp_off;

  dsd_scratch_map #(
    .AW(ADDR_W), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CHUNK_LG(CHUNK_LG)
  ) u_scratch (
    .priv_hit (priv_hit),
    .comb_hit (comb_hit),
    .priv_off (priv_off),
    .comb_off (comb_off),
    .req_id   (in_req_id),
    .ok       (sp_ok),
    .chunk    (sp_chunk),
    .offset   (sp_off)
  );

  // ---------------- combinational select ----------------
  region_e           d_region;
  logic [IDX_W-1:0]  d_chunk;
  logic [ADDR_W-1:0] d_off;
  logic              d_err;

  always_comb begin
    d_region = REG_NONE;
    d_chunk  = '0;
    d_off    = '0;
    d_err    = 1'b0;
    if (exec_hit) begin
      d_region = REG_EXEC;
      d_off    = exec_off;
    end else if (priv_hit || comb_hit) begin
      if (sp_ok) begin
        d_region = priv_hit ? REG_PRIV : REG_COMB;
        d_chunk  = sp_chunk;
        d_off    = sp_off;
      end else begin
        d_err    = 1'b1;
      end
    end else if (dma_hit) begin
      d_region = REG_DMA;
      d_chunk  = in_req_id;
      d_off    = dma_off;
    end else if (dram_hit) begin
      d_region = REG_DRAM;
      d_off    = dram_off;
    end else begin
      d_err    = 1'b1;
    end
  end

  // ---------------- output register ----------------
  region_e           q_region;
  logic [IDX_W-1:0]  q_chunk;
  logic [ADDR_W-1:0] q_off;
  logic              q_err;
  logic              q_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_region <= REG_NONE;
      q_chunk  <= '0;
      q_off    <= '0;
      q_err    <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_region <= d_region;
        q_chunk  <= d_chunk;
        q_off    <= d_off;
        q_err    <= d_err;
      end
    end
  end

  assign out_valid  = q_valid;
  assign out_region = q_region;
  assign out_chunk  = q_chunk;
  assign out_offset = q_off;
  assign out_err    = q_err;

  // ---------------- assertions ----------------
  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_region) && $stable(out_chunk)
                   && $stable(out_offset) && $stable(out_err))); // R2

  AST_ERR_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_region == REG_NONE && out_chunk == '0 && out_offset == '0)); // R10

  AST_PRIV_OWN_CHUNK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && priv_hit && !exec_hit) |=>
      (out_err || (out_region == REG_PRIV && out_chunk == $past(in_req_id)))); // R4

  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_region == REG_PRIV || out_region == REG_COMB))
      |-> (out_offset < CHUNK_BYTES)); // R6

  AST_DMA_BOUND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_region == REG_DMA) |-> (out_offset < DMA_SPAN)); // R8

endmodule

// File: tb/tb_dual_view_addr_decoder.sv
`timescale 1ns/1ps
module tb_dual_view_addr_decoder;

  localparam int AW = 36;
  localparam int IW = 3;
  localparam logic [AW-1:0] CHUNK = 36'h0_0010_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [IW-1:0] in_req_id = '0;
  logic          out_valid;
  logic [2:0]    out_region;
  logic [IW-1:0] out_chunk;
  logic [AW-1:0] out_offset;
  logic          out_err;

  always #2 clk = ~clk; // 250 MHz

  dual_view_addr_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_req_id(in_req_id), .out_valid(out_valid), .out_region(out_region),
    .out_chunk(out_chunk), .out_offset(out_offset), .out_err(out_err));

  typedef struct packed {
    logic [2:0]    region;
    logic [IW-1:0] chunk;
    logic [AW-1:0] offset;
    logic          err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  task automatic check(input string tag, input bit ok, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // Driver: one request per call, expected result pushed to scoreboard.
  task automatic send(input logic [AW-1:0] a, input logic [IW-1:0] id,
                      input logic [2:0] reg_e, input logic [IW-1:0] ch,
                      input logic [AW-1:0] off, input logic err, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    in_addr   = a;
    in_req_id = id;
    e.region = reg_e; e.chunk = ch; e.offset = off; e.err = err;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares every produced result with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2", 1'b0, "result with no pending request");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_region == e.region && out_chunk == e.chunk &&
                 out_offset == e.offset && out_err == e.err,
              $sformatf("got region=%0d chunk=%0d off=%h err=%0b exp region=%0d chunk=%0d off=%h err=%0b",
                        out_region, out_chunk, out_offset, out_err,
                        e.region, e.chunk, e.offset, e.err));
      end
    end
  end

  initial begin : watchdog
    int cyc;
    for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    exp_t last;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", out_valid == 0 && out_region == 0 && out_chunk == 0 && out_offset == 0 && out_err == 0,
          $sformatf("reset outputs v=%0b r=%0d c=%0d o=%h e=%0b exp all zero",
                    out_valid, out_region, out_chunk, out_offset, out_err));
    rst = 1'b0;
    @(negedge clk);
    check("R1", out_valid == 0 && out_region == 0 && out_err == 0,
          $sformatf("post-reset v=%0b r=%0d e=%0b exp 0", out_valid, out_region, out_err));

    // R3 executable
    send(36'h0_0000_1000, 3'd3, 3'd1, 3'd0, 36'h0, 1'b0, "R3");
    send(36'h0_001F_FFFF, 3'd5, 3'd1, 3'd0, 36'h0_001F_EFFF, 1'b0, "R3");
    // R4 private
    send(36'h0_1000_0000, 3'd2, 3'd2, 3'd2, 36'h0, 1'b0, "R4");
    send(36'h0_100F_FFFF, 3'd6, 3'd2, 3'd6, 36'h0_000F_FFFF, 1'b0, "R4");
    // R5 private overflow
    send(36'h0_1010_0000, 3'd1, 3'd0, 3'd0, 36'h0, 1'b1, "R5");
    send(36'h0_103F_FFFF, 3'd4, 3'd0, 3'd0, 36'h0, 1'b1, "R5");
    // R6 combined
    send(36'h0_1800_0000, 3'd4, 3'd3, 3'd0, 36'h0, 1'b0, "R6");
    send(36'h0_187F_FFFF, 3'd0, 3'd3, 3'd7, 36'h0_000F_FFFF, 1'b0, "R6");
    send(36'h0_1834_5678, 3'd6, 3'd3, 3'd3, 36'h0_0004_5678, 1'b0, "R6");
    // R7 alias agreement for each core
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] d;
      d = 36'h0_0000_0ABC + AW'(k) * 36'h0_0001_1110;
      send(36'h0_1000_0000 + d, IW'(k), 3'd2, IW'(k), d, 1'b0, "R7");
      send(36'h0_1800_0000 + AW'(k) * CHUNK + d, IW'(7 - k), 3'd3, IW'(k), d, 1'b0, "R7");
    end
    // R8 DMA registers
    send(36'h0_2000_2000, 3'd7, 3'd4, 3'd7, 36'h0, 1'b0, "R8");
    send(36'h0_2000_20FF, 3'd0, 3'd4, 3'd0, 36'h0_0000_00FF, 1'b0, "R8");
    // R9 DRAM
    send(36'h0_4000_0000, 3'd1, 3'd5, 3'd0, 36'h0, 1'b0, "R9");
    send(36'h1_3FFF_FFFF, 3'd2, 3'd5, 3'd0, 36'h0_FFFF_FFFF, 1'b0, "R9");
    // R10 unmapped, including neighbours of every range end
    send(36'h0_0000_0FFF, 3'd0, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_0020_0000, 3'd1, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_0FFF_FFFF, 3'd2, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_1040_0000, 3'd3, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_17FF_FFFF, 3'd4, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_1880_0000, 3'd5, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_2000_1FFF, 3'd6, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_2000_2100, 3'd7, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_3FFF_FFFF, 3'd0, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h1_4000_0000, 3'd1, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    send(36'h0_1234_5678, 3'd2, 3'd0, 3'd0, 36'h0, 1'b1, "R10");
    // R2: last valid result then idle cycles hold outputs
    send(36'h0_1822_0010, 3'd5, 3'd3, 3'd2, 36'h0_0002_0010, 1'b0, "R2");
    last.region = 3'd3; last.chunk = 3'd2; last.offset = 36'h0_0002_0010; last.err = 1'b0;
    idle();
    // The request above surfaces on this negedge; the idle cycle ends next.
    @(negedge clk);
    check("R2", out_valid == 0 && out_region == last.region && out_chunk == last.chunk &&
               out_offset == last.offset && out_err == last.err,
          $sformatf("idle v=%0b r=%0d c=%0d o=%h exp v=0 r=3 c=2 o=%h",
                    out_valid, out_region, out_chunk, out_offset, last.offset));
    in_addr = 36'h0_0000_0000; // an unmapped address while idle must not show
    @(negedge clk);
    check("R2", out_valid == 0 && out_region == last.region && out_err == 0,
          $sformatf("idle2 v=%0b r=%0d e=%0b exp v=0 r=3 e=0", out_valid, out_region, out_err));
    check("R2", exp_q.size() == 0,
          $sformatf("pending results %0d exp 0", exp_q.size()));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule